// File: doc/BRIEF.md
# Watchdog Reset Router

This block is a countdown watchdog whose single expiry event is fanned out to several consequences at once. Software loads a reload value, enables the count and restarts it periodically with a kick strobe. If the kicks stop, the counter reaches zero and produces a timeout. The counter then reloads and keeps counting.

Each timeout is routed to exactly one reset scope: processor only, a masked set of peripherals, the whole system, or no reset at all. Independently of that choice, a timeout can also set a sticky alternate-boot select. It can also launch a timed pulse on an external pin. That pin can run as open-drain or push-pull, and its polarity is selectable. All settings come through a small write-only register port.

The external pin is presented as separate data and output-enable lines for a pad cell outside the block.

Top module: `wdt_reset_router`

## Requirements
- R1: The action register (address 6) field bits [1:0] selects the reset scope: 0 = none, 1 = processor, 2 = peripheral subset, 3 = whole system. At most one of `cpu_rst_o`, `sys_rst_o` and any bit of `soc_rst_o` is high in any cycle, and only the selected scope is asserted on a timeout.
- R2: After `rst`, the following hold: the scope is whole system, the enable (address 1 bit 0) is off, and the alternate-boot, external-pulse, push-pull and active-high options are off. All reset outputs and `alt_boot_o` are low, and the pin is released (`ext_pin_oe_o` = 0).
- R3: A write to address 5 (kick) reloads the counter from the reload register (address 0). When enabled, the counter decrements every cycle and times out in the cycle after it holds zero, so consecutive timeouts are reload+1 cycles apart. A kick in the cycle where the counter holds zero wins, and no timeout occurs. A disabled counter never times out.
- R4: With the peripheral scope, `soc_rst_o` equals the mask captured at the timeout. Mask word 0 (bits 31:0) is at address 3 and word 1 (bits 63:32) is at address 4. The number of words is the parameter MASK_WORDS.
- R5: The whole-system scope asserts `sys_rst_o`. With scope none, no reset output is asserted, but the external pulse and the alternate-boot select still act.
- R6: With the alternate-boot option (action bit 2) set, a timeout sets `alt_boot_o`. It then stays high until `rst`, whatever later configuration is written.
- R7: With the external-pulse option (action bit 3) set, a timeout starts one pulse lasting D × CYC_PER_US cycles. D is the duration register (address 2), and D = 0 is treated as 1 microsecond.
- R8: In open-drain mode (action bit 4 clear), `ext_pin_o` is 0 and `ext_pin_oe_o` is high only during the pulse. In push-pull mode, `ext_pin_oe_o` is always high.
- R9: The pulse is active-high only when both push-pull and active-high (action bit 5) are set. Otherwise it is active-low, and in open-drain mode the active-high bit has no effect.
- R10: Each asserted reset output rises one cycle after the timeout and stays high for exactly HOLD_CYCLES (16) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| cpu_rst_o | output | 1 | Processor reset pulse |
| soc_rst_o | output | 32*MASK_WORDS | Per-peripheral reset pulses, masked |
| sys_rst_o | output | 1 | Whole-system reset pulse |
| alt_boot_o | output | 1 | Sticky alternate-boot select |
| ext_pin_o | output | 1 | External pin data |
| ext_pin_oe_o | output | 1 | External pin output enable |

## Verification
A kick strobe and counter expiry can land in the same cycle, and the design must treat the kick as the winner. The bench provokes this by kicking at intervals of exactly reload+1 cycles, then repeats the run with the interval one cycle longer. In the first run, every reset output and the external pin must stay idle. In the second run, resets must appear. A behavioural reference model compares every output on every clock, so a pulse that is early, late or one cycle too long is reported at the cycle where it diverges.

// File: rtl/wdt_rr_pkg.sv
package wdt_rr_pkg;

  typedef enum logic [1:0] {
    SCOPE_NONE = 2'd0,
    SCOPE_CPU  = 2'd1,
    SCOPE_SOC  = 2'd2,
    SCOPE_SYS  = 2'd3
  } scope_e;

  typedef struct packed {
    logic   act_high;
    logic   push_pull;
    logic   ext_en;
    logic   alt_en;
    scope_e scope;
  } action_t;

  localparam logic [2:0] A_RELOAD = 3'd0;
  localparam logic [2:0] A_ENABLE = 3'd1;
  localparam logic [2:0] A_DUR    = 3'd2;
  localparam logic [2:0] A_MASK0  = 3'd3;
  localparam logic [2:0] A_KICK   = 3'd5;
  localparam logic [2:0] A_ACTION = 3'd6;

  localparam action_t ACTION_RST = '{act_high: 1'b0, push_pull: 1'b0,
                                     ext_en: 1'b0, alt_en: 1'b0,
                                     scope: SCOPE_SYS};

endpackage

// File: rtl/wdt_rr_regs.sv
module wdt_rr_regs
  import wdt_rr_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DUR_W      = 8,
  parameter int MASK_WORDS = 2,
  localparam int MASK_W    = 32 * MASK_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic [CNT_W-1:0]  reload_q,
  output logic              enable_q,
  output logic [DUR_W-1:0]  dur_q,
  output logic [MASK_W-1:0] mask_q,
  output action_t           action_q,
  output logic              kick
);

  assign kick = wr_en && (wr_addr == A_KICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      enable_q <= 1'b0;
      dur_q    <= '0;
      action_q <= ACTION_RST;
    end else if (wr_en) begin
      case (wr_addr)
        A_RELOAD: reload_q <= wr_data[CNT_W-1:0];
        A_ENABLE: enable_q <= wr_data[0];
        A_DUR:    dur_q    <= wr_data[DUR_W-1:0];
        A_ACTION: action_q <= action_t'(wr_data[5:0]);
        default:  ;
      endcase
    end
  end

  for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[w*32 +: 32] <= '0;
      end else if (wr_en && (wr_addr == 3'(A_MASK0 + w))) begin
        mask_q[w*32 +: 32] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/wdt_rr_counter.sv
module wdt_rr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload,
  output logic             tmo_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '1;
      tmo_o   <= 1'b0;
    end else begin
      tmo_o <= 1'b0;
      if (kick) begin
        count_q <= reload;
      end else if (enable) begin
        if (count_q == '0) begin
          tmo_o   <= 1'b1;
          count_q <= reload;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wdt_rr_resetgen.sv
module wdt_rr_resetgen
  import wdt_rr_pkg::*;
#(
  parameter int MASK_W      = 64,
  parameter int HOLD_CYCLES = 16,
  localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmo,
  input  scope_e            scope,
  input  logic [MASK_W-1:0] mask,
  input  logic              alt_en,
  output logic              cpu_rst_o,
  output logic [MASK_W-1:0] soc_rst_o,
  output logic              sys_rst_o,
  output logic              alt_boot_o
);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      cpu_rst_o <= 1'b0;
      soc_rst_o <= '0;
      sys_rst_o <= 1'b0;
    end else if (tmo) begin
      hold_q    <= HW'(HOLD_CYCLES - 1);
      cpu_rst_o <= (scope == SCOPE_CPU);
      sys_rst_o <= (scope == SCOPE_SYS);
      soc_rst_o <= (scope == SCOPE_SOC) ? mask : '0;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end else begin
      cpu_rst_o <= 1'b0;
      soc_rst_o <= '0;
      sys_rst_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_boot_o <= 1'b0;
    end else if (tmo && alt_en) begin
      alt_boot_o <= 1'b1;
    end
  end

endmodule

// File: rtl/wdt_rr_extpulse.sv
module wdt_rr_extpulse #(
  parameter int DUR_W      = 8,
  parameter int CYC_PER_US = 4,
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [DUR_W-1:0] dur,
  input  logic             push_pull,
  input  logic             act_high,
  output logic             pin_o,
  output logic             pin_oe_o
);

  logic             busy_q;
  logic [PW-1:0]    pre_q;
  logic [DUR_W-1:0] us_left_q;
  logic             high_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      pre_q     <= '0;
      us_left_q <= '0;
    end else if (fire) begin
      busy_q    <= 1'b1;
      pre_q     <= PW'(CYC_PER_US - 1);
      us_left_q <= (dur == '0) ? DUR_W'(1) : dur;
    end else if (busy_q) begin
      if (pre_q == '0) begin
        pre_q     <= PW'(CYC_PER_US - 1);
        us_left_q <= us_left_q - 1'b1;
        if (us_left_q == DUR_W'(1)) begin
          busy_q <= 1'b0;
        end
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign high_active = push_pull & act_high;
  assign pin_oe_o    = push_pull | busy_q;
  assign pin_o       = push_pull ? (high_active ? busy_q : ~busy_q) : 1'b0;

endmodule

// File: rtl/wdt_reset_router.sv
module wdt_reset_router
  import wdt_rr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DUR_W       = 8,
  parameter int CYC_PER_US  = 4,
  parameter int MASK_WORDS  = 2,
  parameter int HOLD_CYCLES = 16,
  localparam int MASK_W     = 32 * MASK_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic              cpu_rst_o,
  output logic [MASK_W-1:0] soc_rst_o,
  output logic              sys_rst_o,
  output logic              alt_boot_o,
  output logic              ext_pin_o,
  output logic              ext_pin_oe_o
);

  logic [CNT_W-1:0]  reload_q;
  logic              enable_q;
  logic [DUR_W-1:0]  dur_q;
  logic [MASK_W-1:0] mask_q;
  action_t           action_q;
  logic              kick;
  logic              tmo;
  logic              pp_mode;

  assign pp_mode = action_q.push_pull;

  wdt_rr_regs #(
    .CNT_W(CNT_W), .DUR_W(DUR_W), .MASK_WORDS(MASK_WORDS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reload_q(reload_q), .enable_q(enable_q), .dur_q(dur_q), .mask_q(mask_q),
    .action_q(action_q), .kick(kick)
  );

  wdt_rr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .enable(enable_q), .kick(kick),
    .reload(reload_q), .tmo_o(tmo)
  );

  wdt_rr_resetgen #(.MASK_W(MASK_W), .HOLD_CYCLES(HOLD_CYCLES)) u_resetgen (
    .clk(clk), .rst(rst), .tmo(tmo), .scope(action_q.scope), .mask(mask_q),
    .alt_en(action_q.alt_en), .cpu_rst_o(cpu_rst_o), .soc_rst_o(soc_rst_o),
    .sys_rst_o(sys_rst_o), .alt_boot_o(alt_boot_o)
  );

  wdt_rr_extpulse #(.DUR_W(DUR_W), .CYC_PER_US(CYC_PER_US)) u_extpulse (
    .clk(clk), .rst(rst), .fire(tmo & action_q.ext_en), .dur(dur_q),
    .push_pull(pp_mode), .act_high(action_q.act_high),
    .pin_o(ext_pin_o), .pin_oe_o(ext_pin_oe_o)
  );

endmodule

// File: rtl/wdt_rr_checker.sv
module wdt_rr_checker #(
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              tmo,
  input logic              pp_mode,
  input logic              cpu_rst,
  input logic [MASK_W-1:0] soc_rst,
  input logic              sys_rst,
  input logic              alt_boot,
  input logic              pin_o,
  input logic              pin_oe
);

  AST_ONE_SCOPE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_rst, sys_rst, |soc_rst})); // R1

  AST_RESET_AFTER_TMO: assert property (@(posedge clk) disable iff (rst)
    ($rose(cpu_rst) || $rose(sys_rst) || $rose(|soc_rst)) |-> $past(tmo)); // R10

  AST_SYS_HELD: assert property (@(posedge clk) disable iff (rst)
    ($rose(sys_rst) && !tmo) |=> sys_rst); // R10

  AST_ALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    alt_boot |=> alt_boot); // R6

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    !pp_mode |-> !pin_o); // R9

  AST_PP_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    pp_mode |-> pin_oe); // R8

endmodule

bind wdt_reset_router wdt_rr_checker #(.MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst(rst), .tmo(tmo), .pp_mode(pp_mode),
  .cpu_rst(cpu_rst_o), .soc_rst(soc_rst_o), .sys_rst(sys_rst_o),
  .alt_boot(alt_boot_o), .pin_o(ext_pin_o), .pin_oe(ext_pin_oe_o)
);

// File: tb/wdt_reset_router_tb.sv
module wdt_reset_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CYC_US     = 4;
  localparam int HOLD       = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cpu_rst_o, sys_rst_o, alt_boot_o, ext_pin_o, ext_pin_oe_o;
  logic [63:0] soc_rst_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit started = 0;

  wdt_reset_router #(.CNT_W(16), .DUR_W(8), .CYC_PER_US(CYC_US),
                     .MASK_WORDS(2), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_rst_o(cpu_rst_o), .soc_rst_o(soc_rst_o), .sys_rst_o(sys_rst_o),
    .alt_boot_o(alt_boot_o), .ext_pin_o(ext_pin_o), .ext_pin_oe_o(ext_pin_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_reload, m_hold, m_us, m_pre, m_dur;
  bit m_en, m_tmo, m_cpu, m_sys, m_alt, m_busy, m_alten, m_exten, m_pp, m_ah;
  bit [1:0]  m_scope;
  bit [63:0] m_mask, m_soc;

  always @(posedge clk) begin
    bit o_tmo, n_tmo, kick;
    started = 1;
    if (rst) begin
      m_cnt = 65535; m_reload = 65535; m_hold = 0; m_us = 0; m_pre = 0; m_dur = 0;
      m_en = 0; m_tmo = 0; m_cpu = 0; m_sys = 0; m_alt = 0; m_busy = 0;
      m_alten = 0; m_exten = 0; m_pp = 0; m_ah = 0; m_scope = 2'd3;
      m_mask = '0; m_soc = '0;
    end else begin
      o_tmo = m_tmo;
      n_tmo = 0;
      kick = wr_en && (wr_addr == 3'd5);
      if (kick) m_cnt = m_reload;
      else if (m_en) begin
        if (m_cnt == 0) begin n_tmo = 1; m_cnt = m_reload; end
        else m_cnt = m_cnt - 1;
      end
      if (o_tmo) begin
        m_hold = HOLD - 1;
        m_cpu = (m_scope == 2'd1);
        m_sys = (m_scope == 2'd3);
        m_soc = (m_scope == 2'd2) ? m_mask : '0;
      end else if (m_hold != 0) m_hold = m_hold - 1;
      else begin m_cpu = 0; m_sys = 0; m_soc = '0; end
      if (o_tmo && m_alten) m_alt = 1;
      if (o_tmo && m_exten) begin
        m_busy = 1; m_us = (m_dur == 0) ? 1 : m_dur; m_pre = CYC_US - 1;
      end else if (m_busy) begin
        if (m_pre == 0) begin
          m_pre = CYC_US - 1;
          if (m_us == 1) m_busy = 0;
          m_us = m_us - 1;
        end else m_pre = m_pre - 1;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_reload = int'(wr_data[15:0]);
          3'd1: m_en = wr_data[0];
          3'd2: m_dur = int'(wr_data[7:0]);
          3'd3: m_mask[31:0] = wr_data;
          3'd4: m_mask[63:32] = wr_data;
          3'd6: begin
            m_scope = wr_data[1:0]; m_alten = wr_data[2]; m_exten = wr_data[3];
            m_pp = wr_data[4]; m_ah = wr_data[5];
          end
          default: ;
        endcase
      end
      m_tmo = n_tmo;
    end
  end

  // window counters
  int n_cpu, n_sys, n_soc, n_oe, n_hi, n_lo, n_win;
  logic [63:0] soc_seen;

  task automatic clear_win();
    n_cpu = 0; n_sys = 0; n_soc = 0; n_oe = 0; n_hi = 0; n_lo = 0; n_win = 0;
    soc_seen = '0;
  endtask

  always @(negedge clk) begin
    if (started) begin
      bit e_pin, e_oe;
      e_oe  = m_pp | m_busy;
      e_pin = m_pp ? ((m_pp & m_ah) ? m_busy : !m_busy) : 1'b0;
      chk("R1 cpu_rst model", 64'(cpu_rst_o), 64'(m_cpu));
      chk("R4 soc_rst model", soc_rst_o, m_soc);
      chk("R5 sys_rst model", 64'(sys_rst_o), 64'(m_sys));
      chk("R6 alt_boot model", 64'(alt_boot_o), 64'(m_alt));
      chk("R9 pin data model", 64'(ext_pin_o), 64'(e_pin));
      chk("R8 pin oe model", 64'(ext_pin_oe_o), 64'(e_oe));
      n_win++;
      if (cpu_rst_o) n_cpu++;
      if (sys_rst_o) n_sys++;
      if (|soc_rst_o) n_soc++;
      if (ext_pin_oe_o) n_oe++;
      if (ext_pin_o === 1'b1) n_hi++;
      if (ext_pin_oe_o && ext_pin_o === 1'b0) n_lo++;
      soc_seen = soc_seen | soc_rst_o;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one timeout with the given action setting (or keep current if use_cfg=0)
  task automatic one_timeout(input bit use_cfg, input logic [31:0] cfg);
    if (use_cfg) wr(3'd6, cfg);
    wr(3'd5, 0);
    clear_win();
    wr(3'd1, 1);
    run(45);
    wr(3'd1, 0);
    run(25);
  endtask

  initial begin
    run(3);
    @(negedge clk);
    rst = 1'b0;
    run(1);
    chk("R2 reset cpu", 64'(cpu_rst_o), 0);
    chk("R2 reset sys", 64'(sys_rst_o), 0);
    chk("R2 reset soc", soc_rst_o, 0);
    chk("R2 reset alt", 64'(alt_boot_o), 0);
    chk("R2 reset pin released", 64'(ext_pin_oe_o), 0);

    wr(3'd0, 40);
    // default scope is whole system
    one_timeout(0, 0);
    chk("R2 R5 default scope sys cycles", n_sys, HOLD);
    chk("R1 default no cpu", n_cpu, 0);
    chk("R1 default no soc", n_soc, 0);

    one_timeout(1, 32'h1);
    chk("R10 cpu hold length", n_cpu, HOLD);
    chk("R1 cpu scope no sys", n_sys, 0);

    wr(3'd3, 32'hA5A5_0001);
    wr(3'd4, 32'h8000_0003);
    one_timeout(1, 32'h2);
    chk("R4 soc mask value", soc_seen, 64'h8000_0003_A5A5_0001);
    chk("R4 soc hold length", n_soc, HOLD);
    chk("R1 soc scope no sys", n_sys, 0);

    wr(3'd2, 3);
    one_timeout(1, 32'h08);
    chk("R5 none scope no resets", n_cpu + n_sys + n_soc, 0);
    chk("R7 od pulse length", n_oe, 3 * CYC_US);
    chk("R8 od never high", n_hi, 0);

    one_timeout(1, 32'h38);
    chk("R9 pp active-high length", n_hi, 3 * CYC_US);
    chk("R8 pp always driven", n_oe, n_win);

    one_timeout(1, 32'h18);
    chk("R9 pp active-low length", n_lo, 3 * CYC_US);

    one_timeout(1, 32'h28);
    chk("R9 od ignores active-high", n_hi, 0);
    chk("R9 od pulse still low", n_oe, 3 * CYC_US);

    wr(3'd2, 0);
    one_timeout(1, 32'h08);
    chk("R7 zero duration is 1us", n_oe, CYC_US);

    one_timeout(1, 32'h04);
    chk("R6 alt set on timeout", 64'(alt_boot_o), 1);
    one_timeout(1, 32'h00);
    chk("R6 alt sticky", 64'(alt_boot_o), 1);

    // kick in the zero cycle wins
    wr(3'd6, 32'h09);
    wr(3'd0, 5);
    wr(3'd5, 0);
    wr(3'd1, 1);
    clear_win();
    for (int i = 0; i < 12; i++) begin
      wr(3'd5, 0);
      run(4);
    end
    chk("R3 zero-cycle kick no reset", n_cpu, 0);
    chk("R3 zero-cycle kick no pulse", n_oe, 0);
    clear_win();
    for (int i = 0; i < 6; i++) begin
      wr(3'd5, 0);
      run(5);
    end
    chk("R3 late kick does time out", 64'(n_cpu != 0), 1);
    wr(3'd1, 0);
    run(30);

    // disabled counter never times out
    wr(3'd5, 0);
    clear_win();
    run(60);
    chk("R3 disabled no timeout", n_cpu + n_oe, 0);

    @(negedge clk);
    rst = 1'b1;
    run(2);
    rst = 1'b0;
    run(1);
    chk("R6 R2 alt cleared by reset", 64'(alt_boot_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule